// File: doc/BRIEF.md
# Gated Dual-Read LUT Memory

This block is a tiny lookup-table memory of sixteen words, one bit wide by default and widened through a parameter. Every bit of a word shares the same addresses, enable and clock. One port writes synchronously and also reads back the word at its own address. A second address reads a second word with no clock at all. Both reads are combinational, so a new address shows its word in the same cycle.

Build-time parameters set the starting contents, the active edge of the write clock and the active level of the write enable. A global gate input holds off every write until the system is ready. This keeps the preloaded contents safe during start-up. While the enable stays inactive, the block acts as a ROM.

Top module: `twin_read_ram`

## Requirements
- R1: The memory has 16 words addressed by 4-bit addresses. `WIDTH` copies of a one-bit cell share both addresses, the enable and the clock, so a word is written and read as a whole.
- R2: On an active clock edge, when the enable is at its active level and the gate is high, `wr_data` is stored in the word at `wr_addr`.
- R3: While the enable is at its inactive level, no word changes, so the block returns its preloaded contents as a ROM.
- R4: `prim_q` is a combinational read of the word at `wr_addr`. Right after a write edge it shows the value just written.
- R5: `sec_q` is a combinational read of the word at `rd_addr`. It follows a change of `rd_addr` with no clock edge, and `rd_addr` never selects a word for writing.
- R6: When `rd_addr` equals `wr_addr`, `sec_q` equals `prim_q`, including right after a write to that word.
- R7: Parameter `INIT` sets the starting contents, with word w held in `INIT[w*WIDTH +: WIDTH]`. Its default is all zeros.
- R8: With `CLK_INV` = 0 the write takes effect on the rising edge of `wr_clk`, and with `CLK_INV` = 1 on the falling edge.
- R9: With `WE_INV` = 0 the enable is active when `wr_en` = 1, and with `WE_INV` = 1 when `wr_en` = 0.
- R10: While `wr_gate` is low, no write takes effect, whatever the enable and the clock do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; the active edge is set by `CLK_INV` |
| wr_gate | input | 1 | Global write gate; writes are blocked while it is low |
| wr_en | input | 1 | Write enable; the active level is set by `WE_INV` |
| wr_addr | input | 4 | Write address and primary read address |
| wr_data | input | WIDTH | Word to be written |
| rd_addr | input | 4 | Secondary read address |
| prim_q | output | WIDTH | Word at `wr_addr` |
| sec_q | output | WIDTH | Word at `rd_addr` |

## Verification
A write and a secondary read can meet in the same cycle on the same word. To provoke this, the bench sets `rd_addr` equal to `wr_addr` during a write. It then judges, just after the active edge, that both outputs carry the new word. A second instance with an inverted clock and an inverted enable is sampled between the two clock edges. It must still hold the old word after the rising edge and show the new word only after the falling edge.

// File: rtl/twin_ram_pkg.sv
package twin_ram_pkg;
  // Resolve a pin level against its polarity choice: 1 means "asserted".
  function automatic logic lvl_on(input logic level, input bit invert);
    return level ^ invert;
  endfunction

  // Bit position of bit b of word w inside a flat init vector.
  function automatic int word_bit_pos(input int w, input int b, input int width);
    return w * width + b;
  endfunction
endpackage

// File: rtl/twr_write_ctrl.sv
module twr_write_ctrl
  import twin_ram_pkg::*;
#(
  parameter bit WE_INV = 1'b0
) (
  input  logic gate_on,
  input  logic en_pin,
  output logic fire
);
  logic en_active;

  assign en_active = lvl_on(en_pin, WE_INV);
  assign fire      = gate_on & en_active;
endmodule

// File: rtl/twr_bit_slice.sv
module twr_bit_slice #(
  parameter int DEPTH                  = 16,
  parameter int AW                     = 4,
  parameter logic [DEPTH-1:0] INIT_COL = '0
) (
  input  logic          act_clk,
  input  logic          gate_on,
  input  logic          fire,
  input  logic [AW-1:0] wr_addr,
  input  logic          d,
  input  logic [AW-1:0] rd_addr,
  output logic          prim,
  output logic          sec
);
  logic [DEPTH-1:0] cells = INIT_COL;
  logic             primed = 1'b0;

  always_ff @(posedge act_clk) begin
    primed <= 1'b1;
    if (fire) cells[wr_addr] <= d;
  end

  assign prim = cells[wr_addr];
  assign sec  = cells[rd_addr];

  // R2: a qualified write lands at the addressed cell
  p_write_lands_r2: assert property (@(posedge act_clk) disable iff (!primed)
    fire |=> cells[$past(wr_addr)] == $past(d));

  // R3: an edge without a qualified write leaves every cell as it was
  p_idle_hold_r3: assert property (@(posedge act_clk) disable iff (!primed)
    !fire |=> $stable(cells));

  // R10: the gate held low protects all contents
  p_gate_blocks_r10: assert property (@(posedge act_clk) disable iff (!primed)
    !gate_on |=> $stable(cells));

  // R6: both read ports agree when they address the same cell
  p_collide_match_r6: assert property (@(posedge act_clk) disable iff (!primed)
    (wr_addr == rd_addr) |-> (prim == sec));
endmodule

// File: rtl/twin_read_ram.sv
module twin_read_ram
  import twin_ram_pkg::*;
#(
  parameter int WIDTH                     = 1,
  parameter int DEPTH                     = 16,
  parameter logic [DEPTH*WIDTH-1:0] INIT  = '0,
  parameter bit CLK_INV                   = 1'b0,
  parameter bit WE_INV                    = 1'b0
) (
  input  logic                     wr_clk,
  input  logic                     wr_gate,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [WIDTH-1:0]         prim_q,
  output logic [WIDTH-1:0]         sec_q
);
  localparam int AW = $clog2(DEPTH);

  // Gather the bits of one column (bit b of every word) from the flat init.
  function automatic logic [DEPTH-1:0] column_of(input int b);
    logic [DEPTH-1:0] col;
    for (int w = 0; w < DEPTH; w++) col[w] = INIT[word_bit_pos(w, b, WIDTH)];
    return col;
  endfunction

  logic act_clk;     // active edge always appears as a rising edge here
  logic wr_fire;     // qualified write strobe

  assign act_clk = lvl_on(wr_clk, CLK_INV);

  twr_write_ctrl #(.WE_INV(WE_INV)) u_ctrl (
    .gate_on (wr_gate),
    .en_pin  (wr_en),
    .fire    (wr_fire)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_col
    twr_bit_slice #(
      .DEPTH    (DEPTH),
      .AW       (AW),
      .INIT_COL (column_of(b))
    ) u_col (
      .act_clk (act_clk),
      .gate_on (wr_gate),
      .fire    (wr_fire),
      .wr_addr (wr_addr),
      .d       (wr_data[b]),
      .rd_addr (rd_addr),
      .prim    (prim_q[b]),
      .sec     (sec_q[b])
    );
  end

  // R1: all columns see one strobe, so a blocked gate never yields a write
  p_shared_strobe_r1: assert property (@(posedge act_clk)
    !wr_gate |-> !wr_fire);
endmodule

// File: tb/twin_read_ram_test.sv
`timescale 1ns/100ps
module twin_read_ram_test;
  localparam int W = 4;

  function automatic logic [16*W-1:0] mk_init();
    logic [16*W-1:0] v;
    for (int i = 0; i < 16; i++) v[i*W +: W] = 4'(i) ^ 4'hA;
    return v;
  endfunction
  localparam logic [16*W-1:0] INIT_B = mk_init();

  // {gate, we(logical), waddr, wdata, raddr}
  localparam logic [13:0] VEC [8] = '{
    {1'b0, 1'b1, 4'h3, 4'hF, 4'h3},
    {1'b1, 1'b0, 4'h3, 4'hF, 4'h3},
    {1'b1, 1'b1, 4'h3, 4'hA, 4'h3},
    {1'b1, 1'b1, 4'h7, 4'h5, 4'h3},
    {1'b1, 1'b0, 4'h7, 4'h0, 4'h7},
    {1'b1, 1'b1, 4'h0, 4'hC, 4'hF},
    {1'b0, 1'b1, 4'h0, 4'h1, 4'h0},
    {1'b1, 1'b1, 4'hF, 4'h9, 4'h0}
  };

  logic clk = 1'b0;
  logic gate = 1'b0, we = 1'b0;
  logic [3:0] waddr = '0, raddr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] pa, sa, pb, sb;
  logic [W-1:0] ref_a [16];
  logic [W-1:0] ref_b [16];
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  twin_read_ram #(.WIDTH(W)) uut (
    .wr_clk(clk), .wr_gate(gate), .wr_en(we), .wr_addr(waddr),
    .wr_data(wdata), .rd_addr(raddr), .prim_q(pa), .sec_q(sa));

  twin_read_ram #(.WIDTH(W), .INIT(INIT_B), .CLK_INV(1'b1), .WE_INV(1'b1)) uut_inv (
    .wr_clk(clk), .wr_gate(gate), .wr_en(~we), .wr_addr(waddr),
    .wr_data(wdata), .rd_addr(raddr), .prim_q(pb), .sec_q(sb));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " prim a"}, pa, ref_a[waddr]);
    chk({req, " sec a"},  sa, ref_a[raddr]);
    chk({req, " prim b"}, pb, ref_b[waddr]);
    chk({req, " sec b"},  sb, ref_b[raddr]);
  endtask

  // Drive, let both active edges pass, update the model, compare.
  task automatic step(input logic g, input logic w, input logic [3:0] wa,
                      input logic [W-1:0] wd, input logic [3:0] ra, input string req);
    gate = g; we = w; waddr = wa; wdata = wd; raddr = ra;
    @(posedge clk); @(negedge clk); #0.5;
    if (g && w) begin ref_a[wa] = wd; ref_b[wa] = wd; end
    chk_all(req);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      ref_a[i] = '0;
      ref_b[i] = 4'(i) ^ 4'hA;
    end
    // R7 R5: starting contents, swept through the async secondary port
    for (int i = 0; i < 16; i++) begin
      raddr = 4'(i); waddr = 4'(15 - i); #1;
      chk("R7 default zero", sa, '0);
      chk("R7 init pattern", sb, ref_b[i]);
      chk("R5 async sec", sb, 4'(i) ^ 4'hA);
      chk("R4 async prim", pb, 4'(15 - i) ^ 4'hA);
    end
    // Vector table: R2 R3 R9 R10 R1 R6
    for (int k = 0; k < 8; k++) begin
      step(VEC[k][13], VEC[k][12], VEC[k][11:8], VEC[k][7:4], VEC[k][3:0],
           "R1 R2 R3 R9 R10 vec");
    end
    // R8 R4 R6: polarity of the edge, collision on the same word
    gate = 1'b1; we = 1'b1; waddr = 4'h5; wdata = 4'h6; raddr = 4'h5;
    @(posedge clk); #0.5;
    chk("R8 rising edge wrote", pa, 4'h6);
    chk("R6 collision sec a", sa, 4'h6);
    chk("R8 falling not yet", pb, ref_b[5]);
    @(negedge clk); #0.5;
    chk("R8 falling edge wrote", pb, 4'h6);
    chk("R6 collision sec b", sb, 4'h6);
    ref_a[5] = 4'h6; ref_b[5] = 4'h6;
    we = 1'b0;
    // R10: gate low with enable active over several edges
    step(1'b0, 1'b1, 4'h9, 4'h3, 4'h9, "R10 gated");
    step(1'b0, 1'b1, 4'h9, 4'h4, 4'h2, "R10 gated");
    // R3: ROM sweep with enable inactive across edges
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 4'(i), 4'hF, 4'(15 - i), "R3 rom");
    // R5: sec address is never written through
    step(1'b1, 1'b1, 4'h2, 4'hB, 4'hE, "R5 sec no write");
    raddr = 4'h2; #1;
    chk("R5 sec reads new word", sa, 4'hB);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule